// File: doc/BRIEF.md
# Pause Frame Generator

This block assembles the byte stream of a full-duplex MAC control frame that asks the link partner to hold off transmission. The frame is 60 bytes long. It carries the reserved control multicast destination, the station's own address, the MAC-control type, the pause opcode and a 16-bit pause time counted in quanta of 512 bit times. The rest of the frame is zero fill. The bytes go to a downstream transmit path over a valid/ready stream with start and end markers. That path adds the preamble and the FCS.

A frame can be requested by software with a single-cycle pulse. It can also be requested automatically from the level of the receive buffer: falling below a watermark sends a frame with the programmed pause time, and recovering sends a frame with a zero pause time, which releases the partner. Requests that arrive while a frame is on the wire wait in a one-deep slot, so the block never cuts a frame short.

Stream rules: `out_valid` stays high from the first byte until the end byte is accepted. A byte is taken on each rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the data and the markers hold their values. After each frame, `out_valid` is low for at least one cycle.

Top module: `pause_frame_gen`

## Requirements
- R1: Each frame has exactly 60 accepted bytes. `out_sop` is high only with the first byte and `out_eop` is high only with the 60th. `out_valid` is low in the cycle after the end byte is accepted.
- R2: Bytes 0-5 are 01 80 C2 00 00 01. Bytes 6-11 are `src_addr`, most significant byte first. Bytes 12-13 are 88 08. Bytes 14-15 are 00 01.
- R3: Bytes 16-17 carry the pause value, high byte first. The value is sampled when the frame starts, so later changes to `pause_time` do not alter that frame.
- R4: Bytes 18-59 are all zero.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sop` and `out_eop` keep their values into the next cycle.
- R6: A `manual_req` sampled high at a rising edge while `out_valid` is low gives `out_valid` high after the second rising edge from that one. The frame carries `pause_time`.
- R7: With `auto_en` high, a change from `rx_free >= rx_watermark` to `rx_free < rx_watermark` queues one frame carrying `pause_time`. Staying below the watermark queues nothing further.
- R8: With `auto_en` high, a change from below the watermark back to `rx_free >= rx_watermark` queues one frame whose pause field is 00 00.
- R9: With `auto_en` low, the watermark comparison queues no frame, and the below-watermark state is forgotten.
- R10: Requests that arrive while a frame is in progress merge into one pending request, and the most recent kind wins. That request is sent as a separate frame after the current frame ends.
- R11: Reset is asynchronous and active low. It drops `out_valid` and discards any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pause_time | input | 16 | Pause time register, in 512-bit-time quanta |
| src_addr | input | 48 | Station source address |
| manual_req | input | 1 | Software request; each high cycle counts as one request |
| auto_en | input | 1 | Enables watermark-driven requests |
| rx_free | input | FREE_W | Free space in the receive buffer |
| rx_watermark | input | FREE_W | Low-space threshold |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Downstream accepts a byte |
| out_data | output | 8 | Stream byte |
| out_sop | output | 1 | First byte of a frame |
| out_eop | output | 1 | Last byte of a frame |

## Verification
On every cycle, the checker confirms four things: the stream holds its data and markers during back-pressure, the start and end markers match an independent count of accepted bytes, each frame opens with the multicast byte, and a software request on an idle stream produces valid two edges later. Some behaviour can only be seen over whole scenarios in the bench. This covers the full byte content under different addresses and pause values, the capture of the pause value at frame start, the merging of requests that arrive mid-frame, the edge-triggered pause and release frames driven by the watermark, the inert behaviour when automatic mode is off, and the clearing of a pending request by reset.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int FRAME_BYTES = 60;
  localparam int HDR_BYTES   = 18;
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  localparam logic [47:0] CTRL_DA    = 48'h0180C2000001;
  localparam logic [15:0] CTRL_ETYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPC  = 16'h0001;

  typedef logic [IDX_W-1:0] idx_t;

  // one-deep pending slot: vld = something queued, zero = release frame
  typedef struct packed {
    logic vld;
    logic zero;
  } req_t;
endpackage

// File: rtl/pfg_trigger.sv
module pfg_trigger
  import pfg_pkg::*;
#(
  parameter int FREE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              manual_req,
  input  logic              auto_en,
  input  logic [FREE_W-1:0] rx_free,
  input  logic [FREE_W-1:0] rx_watermark,
  input  logic              take,
  output req_t              pend
);
  logic below;
  logic starved_q;
  logic auto_pause;
  logic auto_rel;
  logic set_req;
  logic set_zero;

  assign below      = rx_free < rx_watermark;
  assign auto_pause = auto_en & ~starved_q & below;
  assign auto_rel   = auto_en & starved_q & ~below;
  assign set_req    = manual_req | auto_pause | auto_rel;
  // a pause request of any source outranks a release in the same cycle
  assign set_zero   = auto_rel & ~manual_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      starved_q <= 1'b0;
    end else begin
      starved_q <= auto_en & below;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (set_req) begin
      pend.vld  <= 1'b1;
      pend.zero <= set_zero;
    end else if (take) begin
      pend <= '0;
    end
  end
endmodule

// File: rtl/pfg_emitter.sv
module pfg_emitter
  import pfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  req_t        pend,
  input  logic [15:0] pause_time,
  input  logic        out_ready,
  output logic        take,
  output idx_t        idx,
  output logic [15:0] pt_q,
  output logic        out_valid,
  output logic        out_sop,
  output logic        out_eop
);
  localparam idx_t LAST_IDX = idx_t'(FRAME_BYTES - 1);

  logic busy_q;
  logic fire;
  logic last;

  assign take = pend.vld & ~busy_q;
  assign fire = busy_q & out_ready;
  assign last = idx == LAST_IDX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx    <= '0;
      pt_q   <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      idx    <= '0;
      pt_q   <= pend.zero ? 16'h0000 : pause_time;
    end else if (fire) begin
      if (last) begin
        busy_q <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + idx_t'(1);
      end
    end
  end

  assign out_valid = busy_q;
  assign out_sop   = busy_q & (idx == '0);
  assign out_eop   = busy_q & last;
endmodule

// File: rtl/pfg_byte_mux.sv
module pfg_byte_mux
  import pfg_pkg::*;
(
  input  idx_t        idx,
  input  logic [47:0] src_addr,
  input  logic [15:0] pt_q,
  output logic [7:0]  data
);
  logic [8*HDR_BYTES-1:0] hdr;
  logic [7:0]             hb [HDR_BYTES];

  assign hdr = {CTRL_DA, src_addr, CTRL_ETYPE, PAUSE_OPC, pt_q};

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    assign hb[g] = hdr[8*(HDR_BYTES-g)-1 -: 8];
  end

  always_comb begin
    data = 8'h00;
    for (int i = 0; i < HDR_BYTES; i++) begin
      if (idx == idx_t'(i)) data = hb[i];
    end
  end
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pfg_pkg::*;
#(
  parameter int FREE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       pause_time,
  input  logic [47:0]       src_addr,
  input  logic              manual_req,
  input  logic              auto_en,
  input  logic [FREE_W-1:0] rx_free,
  input  logic [FREE_W-1:0] rx_watermark,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop
);
  req_t        pend;
  logic        take;
  idx_t        idx;
  logic [15:0] pt_q;

  pfg_trigger #(.FREE_W(FREE_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .manual_req(manual_req), .auto_en(auto_en),
    .rx_free(rx_free), .rx_watermark(rx_watermark), .take(take), .pend(pend)
  );

  pfg_emitter u_emit (
    .clk(clk), .rst_n(rst_n), .pend(pend), .pause_time(pause_time),
    .out_ready(out_ready), .take(take), .idx(idx), .pt_q(pt_q),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop)
  );

  pfg_byte_mux u_mux (
    .idx(idx), .src_addr(src_addr), .pt_q(pt_q), .data(out_data)
  );
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker
  import pfg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       manual_req,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_eop
);
  int unsigned seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 0;
    else if (out_valid && out_ready) seen <= out_eop ? 0 : seen + 1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)); // R5
  AST_SOP_POS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sop == (seen == 0)); // R1
  AST_EOP_POS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_eop == (seen == FRAME_BYTES - 1)); // R1
  AST_GAP_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eop |=> !out_valid); // R1
  AST_DA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> out_data == 8'h01); // R2
  AST_MANUAL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    manual_req && !out_valid |-> ##2 out_valid); // R6
endmodule

bind pause_frame_gen pfg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .manual_req(manual_req), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
);

// File: tb/tb_pause_frame_gen.sv
`timescale 1ns/1ps
module tb_pause_frame_gen;
  localparam int FW = 16;
  localparam int NB = 60;
  // {pause_time, src_addr}
  localparam logic [63:0] VECS [4] = '{
    64'h1234_02AABBCCDDEE, 64'hFFFF_FEDCBA987654,
    64'h0001_000000000001, 64'h0000_5A5A5A5A5A5A };

  logic clk = 0, rst_n = 0;
  logic [15:0] pause_time = 0;
  logic [47:0] src_addr = 0;
  logic manual_req = 0, auto_en = 0, out_ready = 0;
  logic [FW-1:0] rx_free = 0, rx_watermark = 0;
  logic out_valid, out_sop, out_eop;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  logic [7:0] got [NB];

  always #2 clk = ~clk;

  pause_frame_gen #(.FREE_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .pause_time(pause_time), .src_addr(src_addr),
    .manual_req(manual_req), .auto_en(auto_en), .rx_free(rx_free),
    .rx_watermark(rx_watermark), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int i, logic [15:0] pt, logic [47:0] sa);
    logic [47:0] da = 48'h0180C2000001;
    if (i < 6)   return da[8*(5-i) +: 8];
    if (i < 12)  return sa[8*(11-i) +: 8];
    if (i == 12) return 8'h88;
    if (i == 13) return 8'h08;
    if (i == 14) return 8'h00;
    if (i == 15) return 8'h01;
    if (i == 16) return pt[15:8];
    if (i == 17) return pt[7:0];
    return 8'h00;
  endfunction

  task automatic pulse();
    manual_req = 1;
    @(negedge clk);
    manual_req = 0;
  endtask

  task automatic get_frame(input int stall, input string req);
    int n = 0;
    int t = 0;
    bit mbad = 0;
    while (n < NB && t < 3000) begin
      out_ready = (stall == 0) ? 1'b1 : ((t % 3) != 0);
      if (out_valid && out_ready) begin
        if (out_sop != (n == 0) || out_eop != (n == NB-1)) mbad = 1;
        got[n] = out_data;
        n++;
      end
      t++;
      @(negedge clk);
    end
    out_ready = 0;
    check(n == NB && !mbad, req, "frame byte count / markers", n, NB);
  endtask

  task automatic cmp_frame(input logic [15:0] pt, input logic [47:0] sa, input string req);
    int bad = -1;
    for (int i = NB-1; i >= 0; i--) if (got[i] !== exp_byte(i, pt, sa)) bad = i;
    if (bad < 0) check(1, req, "frame content", 0, 0);
    else check(0, req, $sformatf("byte %0d", bad), got[bad], exp_byte(bad, pt, sa));
  endtask

  task automatic idle_check(input int cyc, input string req);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (out_valid) seen = 1;
    end
    check(!seen, req, "no frame expected", seen, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R11", "valid during reset", out_valid, 0);
    rst_n = 1;
    idle_check(5, "R11");

    // table walk: R1 R2 R3 R4, alternate stalls for R5
    for (int v = 0; v < 4; v++) begin
      pause_time = VECS[v][63:48];
      src_addr   = VECS[v][47:0];
      pulse();
      get_frame(v % 2, "R1");
      cmp_frame(VECS[v][63:48], VECS[v][47:0], "R2/R3/R4");
      @(negedge clk);
    end

    // R6 latency, R5 hold
    pause_time = 16'hBEEF; src_addr = 48'h112233445566;
    pulse();
    check(out_valid == 0, "R6", "valid one edge after request", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1, "R6", "valid two edges after request", out_valid, 1);
    begin
      bit held = 1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (!out_valid || !out_sop || out_data !== 8'h01) held = 0;
      end
      check(held, "R5", "first byte held under back-pressure", held, 1);
    end
    // R3: change register after frame start
    pause_time = 16'h0BAD;
    get_frame(0, "R3");
    cmp_frame(16'hBEEF, 48'h112233445566, "R3");
    @(negedge clk);

    // R10: requests during a frame merge into one following frame
    pause_time = 16'h0102;
    pulse();
    @(negedge clk);
    pulse();
    pulse();
    pause_time = 16'h0304;
    get_frame(0, "R10");
    cmp_frame(16'h0102, 48'h112233445566, "R10");
    get_frame(1, "R10");
    cmp_frame(16'h0304, 48'h112233445566, "R10");
    idle_check(10, "R10");

    // R7 / R8 automatic mode
    pause_time = 16'h00F0;
    rx_watermark = 100; rx_free = 200; auto_en = 1;
    idle_check(10, "R7");
    rx_free = 99;
    get_frame(0, "R7");
    cmp_frame(16'h00F0, 48'h112233445566, "R7");
    rx_free = 5;
    idle_check(12, "R7");
    rx_free = 100;
    get_frame(0, "R8");
    cmp_frame(16'h0000, 48'h112233445566, "R8");
    idle_check(10, "R8");

    // R9 automatic off
    auto_en = 0; rx_free = 3;
    idle_check(12, "R9");
    rx_free = 300;
    idle_check(6, "R9");

    // R11 reset mid-frame clears pending request
    pulse();
    @(negedge clk);
    pulse();
    rst_n = 0;
    @(negedge clk);
    check(out_valid == 0, "R11", "valid after reset mid-frame", out_valid, 0);
    rst_n = 1;
    idle_check(10, "R11");

    finish_run();
  end
endmodule